// File: doc/BRIEF.md
# Snooping Write-Back Line Coherence Controller

This block keeps one private, direct-mapped, write-back cache coherent with its peers on a shared bus. Every line carries one of three states: Invalid, Clean (same value as shared memory) or Dirty (the only up-to-date copy). On one side it serves processor reads and writes. On the other side it watches the transactions that other caches place on the bus. The tag/state directory has two lookup ports, so snoops are handled in the same cycles as processor accesses and never wait for them.

The block starts every bus transaction it needs: line reads, reads for ownership, write-backs of dirty victims, and address-only invalidations. When another cache wants a line that is Dirty here, this block answers with a hit, drives the data on its supply port and drops its own copy to Clean or Invalid. Each line is one data word, and the data array is a register model inside the directory. The processor holds its request stable until it sees ready. The bus side handles one transaction at a time: the controller holds bus_req_o with its command and address until bus_ack_i arrives. Read data is returned on bus_rdata_i in the cycle of the acknowledge.

Top module: `snp_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid and cpu_ready_o, bus_req_o, snp_hit_o and snp_supply_o are low. A snoop before any access therefore reports no hit.
- R2: A processor read that misses raises bus_req_o with command code 0 (read) at the line address. The line is installed Clean with bus_rdata_i, and ready with that data follows in the cycle after the acknowledge. A read hit raises cpu_ready_o in the cycle of the request and makes no bus transaction.
- R3: A processor write that misses issues command code 1 (read for ownership), installs the line Dirty holding the write data, and completes with no further bus traffic.
- R4: A processor write that hits a Clean line first issues command code 2, an address-only invalidation, then makes the line Dirty with the new data.
- R5: A processor write that hits a Dirty line completes in the cycle of the request with no bus transaction.
- R6: A miss whose victim line is Dirty first issues command code 3 (write-back) with the victim address and data, then the fill. A Clean or Invalid victim is replaced with the fill alone.
- R7: A snooped read (code 0) that hits a Dirty line answers with hit and supply, drives the line data, and leaves the line Clean. A snooped read that hits a Clean line answers hit without supply.
- R8: A snooped read for ownership (code 1) or invalidation (code 2) that hits a valid line makes it Invalid. Supply is raised only for a read for ownership that hits a Dirty line.
- R9: A snoop whose tag does not match, or that hits an Invalid line, or that carries code 3 (write-back), gives no hit and does not change the line.
- R10: The snoop response appears in the cycle right after the snoop address cycle and lasts one cycle.
- R11: A processor access to the same index as a snoop in the same cycle is held off for that cycle and completes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_addr_i | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request complete |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | 0 read, 1 read for ownership, 2 invalidate, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_ack_i | input | 1 | Transaction done |
| bus_rdata_i | input | DATA_W | Fill data, valid with acknowledge |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same codes as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_hit_o | output | 1 | Snoop found a valid copy |
| snp_supply_o | output | 1 | This cache supplies the data |
| snp_data_o | output | DATA_W | Supplied data |

## Verification
A wrong line state shows at the ports in a fixed way. A line left Dirty when it should have dropped to Clean lets the next write finish with no invalidation, and it shows up again as a write-back when the line is replaced. A line wrongly left valid answers the next snoop with a hit one cycle after that snoop's address cycle. It also lets the next processor read complete with no bus read. For this reason the bench follows every snoop with a snoop or processor access to the same line, and compares the ordered bus, ready and snoop-response events against a queue of expected events.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_CLN = 2'd1,
    LN_DRT = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_INV = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/snp_dir.sv
module snp_dir
  import snp_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output line_st_e          cpu_st_o,
  output logic [DATA_W-1:0] cpu_dat_o,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic [TAG_W-1:0]  snp_tag_o,
  output line_st_e          snp_st_o,
  output logic [DATA_W-1:0] snp_dat_o,
  input  logic              snp_upd_i,
  input  line_st_e          snp_st_new_i,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  line_st_e          wr_st_i,
  input  logic [DATA_W-1:0] wr_dat_i,
  input  logic              cnd_en_i,
  input  logic [TAG_W-1:0]  cnd_tag_i,
  input  line_st_e          cnd_from_i,
  input  line_st_e          cnd_to_i
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_a [LINES];
  line_st_e          st_a  [LINES];
  logic [DATA_W-1:0] dat_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    line_st_e          st_q;
    line_st_e          st_snp;
    logic              cpu_sel;
    logic              cnd_hit;

    assign cpu_sel = (cpu_idx_i == MY_IDX);
    // snoop effect first, processor action applied on top
    always_comb st_snp = (snp_upd_i && snp_idx_i == MY_IDX) ? snp_st_new_i : st_q;
    assign cnd_hit = cnd_en_i && cpu_sel && (st_snp == cnd_from_i) && (tag_q == cnd_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        dat_q <= '0;
        st_q  <= LN_INV;
      end else if (wr_en_i && cpu_sel) begin
        tag_q <= wr_tag_i;
        dat_q <= wr_dat_i;
        st_q  <= wr_st_i;
      end else if (cnd_hit) begin
        st_q  <= cnd_to_i;
      end else begin
        st_q  <= st_snp;
      end
    end

    assign tag_a[g] = tag_q;
    assign st_a[g]  = st_q;
    assign dat_a[g] = dat_q;
  end

  assign cpu_tag_o = tag_a[cpu_idx_i];
  assign cpu_st_o  = st_a[cpu_idx_i];
  assign cpu_dat_o = dat_a[cpu_idx_i];
  assign snp_tag_o = tag_a[snp_idx_i];
  assign snp_st_o  = st_a[snp_idx_i];
  assign snp_dat_o = dat_a[snp_idx_i];
endmodule

// File: rtl/snp_resp.sv
module snp_resp
  import snp_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  bus_cmd_e          snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_dat_i,
  output logic              upd_o,
  output line_st_e          st_new_o,
  output logic              hit_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o
);
  logic match, give;

  always_comb begin
    match    = snp_valid_i && (line_st_i != LN_INV) && (line_tag_i == snp_tag_i)
               && (snp_cmd_i != BC_WB);
    give     = 1'b0;
    st_new_o = line_st_i;
    unique case (snp_cmd_i)
      BC_RD: begin
        give     = (line_st_i == LN_DRT);
        st_new_o = (line_st_i == LN_DRT) ? LN_CLN : line_st_i;
      end
      BC_RDX: begin
        give     = (line_st_i == LN_DRT);
        st_new_o = LN_INV;
      end
      BC_INV:  st_new_o = LN_INV;
      default: st_new_o = line_st_i;
    endcase
  end

  assign upd_o = match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      supply_o <= 1'b0;
      data_o   <= '0;
    end else begin
      hit_o    <= match;
      supply_o <= match && give;
      data_o   <= (match && give) ? line_dat_i : '0;
    end
  end
endmodule

// File: rtl/snp_cpu_fsm.sv
module snp_cpu_fsm
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_dat_i,
  input  logic              snp_valid_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              wr_en_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output line_st_e          wr_st_o,
  output logic [DATA_W-1:0] wr_dat_o,
  output logic              cnd_en_o,
  output logic [TAG_W-1:0]  cnd_tag_o,
  output line_st_e          cnd_from_o,
  output line_st_e          cnd_to_o
);
  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPG} fsm_e;

  fsm_e st_q, st_d;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  logic hit, blocked;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign hit     = (line_st_i != LN_INV) && (line_tag_i == cpu_tag);
  assign blocked = snp_valid_i && (snp_idx_i == cpu_idx);
  assign cpu_rdata_o = line_dat_i;

  always_comb begin
    st_d        = st_q;
    cpu_ready_o = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_RD;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = '0;
    wr_en_o     = 1'b0;
    wr_tag_o    = cpu_tag;
    wr_st_o     = LN_DRT;
    wr_dat_o    = cpu_wdata_i;
    cnd_en_o    = 1'b0;
    cnd_tag_o   = cpu_tag;
    cnd_from_o  = LN_DRT;
    cnd_to_o    = LN_CLN;
    unique case (st_q)
      F_IDLE: begin
        if (cpu_req_i && !blocked) begin
          if (hit && !cpu_we_i) begin
            cpu_ready_o = 1'b1;
          end else if (hit && line_st_i == LN_DRT) begin
            cpu_ready_o = 1'b1;
            wr_en_o     = 1'b1;
          end else if (hit) begin
            st_d = F_UPG;
          end else if (line_st_i == LN_DRT) begin
            st_d = F_WB;
          end else begin
            st_d = F_FILL;
          end
        end
      end
      F_WB: begin
        // withdraw if a snoop already took the dirty copy
        if (line_st_i == LN_DRT) begin
          bus_req_o   = 1'b1;
          bus_cmd_o   = BC_WB;
          bus_addr_o  = {line_tag_i, cpu_idx};
          bus_wdata_o = line_dat_i;
          if (bus_ack_i) begin
            cnd_en_o  = 1'b1;
            cnd_tag_o = line_tag_i;
            st_d      = F_FILL;
          end
        end else begin
          st_d = F_FILL;
        end
      end
      F_FILL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = cpu_we_i ? BC_RDX : BC_RD;
        if (bus_ack_i) begin
          wr_en_o  = 1'b1;
          wr_st_o  = cpu_we_i ? LN_DRT : LN_CLN;
          wr_dat_o = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
          st_d     = F_IDLE;
        end
      end
      F_UPG: begin
        // upgrade only while the clean copy survives; else retry as a miss
        if (line_st_i == LN_CLN && line_tag_i == cpu_tag) begin
          bus_req_o = 1'b1;
          bus_cmd_o = BC_INV;
          if (bus_ack_i) begin
            cnd_en_o   = 1'b1;
            cnd_from_o = LN_CLN;
            cnd_to_o   = LN_DRT;
            st_d       = F_IDLE;
          end
        end else begin
          st_d = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= F_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/snp_cache_ctrl.sv
module snp_cache_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_hit_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]  c_tag, s_tag, wr_tag, cnd_tag;
  logic [DATA_W-1:0] c_dat, s_dat, wr_dat;
  line_st_e          c_st, s_st, s_new, wr_st, cnd_from, cnd_to;
  logic              s_upd, wr_en, cnd_en;
  bus_cmd_e          cmd;

  assign bus_cmd_o = cmd;

  snp_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_idx_i    (cpu_addr_i[IDX_W-1:0]),
    .cpu_tag_o    (c_tag),
    .cpu_st_o     (c_st),
    .cpu_dat_o    (c_dat),
    .snp_idx_i    (snp_addr_i[IDX_W-1:0]),
    .snp_tag_o    (s_tag),
    .snp_st_o     (s_st),
    .snp_dat_o    (s_dat),
    .snp_upd_i    (s_upd),
    .snp_st_new_i (s_new),
    .wr_en_i      (wr_en),
    .wr_tag_i     (wr_tag),
    .wr_st_i      (wr_st),
    .wr_dat_i     (wr_dat),
    .cnd_en_i     (cnd_en),
    .cnd_tag_i    (cnd_tag),
    .cnd_from_i   (cnd_from),
    .cnd_to_i     (cnd_to)
  );

  snp_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_tag_i  (s_tag),
    .line_st_i   (s_st),
    .line_dat_i  (s_dat),
    .upd_o       (s_upd),
    .st_new_o    (s_new),
    .hit_o       (snp_hit_o),
    .supply_o    (snp_supply_o),
    .data_o      (snp_data_o)
  );

  snp_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_ready_o (cpu_ready_o),
    .cpu_rdata_o (cpu_rdata_o),
    .line_tag_i  (c_tag),
    .line_st_i   (c_st),
    .line_dat_i  (c_dat),
    .snp_valid_i (snp_valid_i),
    .snp_idx_i   (snp_addr_i[IDX_W-1:0]),
    .bus_req_o   (bus_req_o),
    .bus_cmd_o   (cmd),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .wr_en_o     (wr_en),
    .wr_tag_o    (wr_tag),
    .wr_st_o     (wr_st),
    .wr_dat_o    (wr_dat),
    .cnd_en_o    (cnd_en),
    .cnd_tag_o   (cnd_tag),
    .cnd_from_o  (cnd_from),
    .cnd_to_o    (cnd_to)
  );
endmodule

// File: rtl/snp_cache_ctrl_chk.sv
module snp_cache_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_hit_o,
  input logic              snp_supply_o
);
  assert_ready_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  assert_resp_follows_snoop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> $past(snp_valid_i));

  assert_supply_needs_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_hit_o);

  assert_no_supply_on_inval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> ($past(snp_cmd_i) != 2'd2));

  assert_cpu_held_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && snp_valid_i && cpu_addr_i[IDX_W-1:0] == snp_addr_i[IDX_W-1:0])
      |-> !cpu_ready_o);
endmodule

bind snp_cache_ctrl snp_cache_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_ready_o  (cpu_ready_o),
  .cpu_addr_i   (cpu_addr_i),
  .snp_valid_i  (snp_valid_i),
  .snp_cmd_i    (snp_cmd_i),
  .snp_addr_i   (snp_addr_i),
  .snp_hit_o    (snp_hit_o),
  .snp_supply_o (snp_supply_o)
);

// File: tb/snp_cache_ctrl_tb.sv
`timescale 1ns/100ps
module snp_cache_ctrl_tb;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic       cpu_ready;
  logic [7:0] cpu_rdata;
  logic       bus_req;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata;
  logic       bus_ack = 0;
  logic [7:0] bus_rdata = 0;
  logic       snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic       snp_hit, snp_supply;
  logic [7:0] snp_data;
  logic       snp_d = 0;

  int n_chk = 0, n_fail = 0, wait_cnt = 0;
  bit done = 0;
  logic [7:0] mem [256];

  typedef struct {int kind; int cmd; int addr; int data; string rq;} ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;

  snp_cache_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_hit_o(snp_hit), .snp_supply_o(snp_supply), .snp_data_o(snp_data)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  function automatic void check(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endfunction

  function automatic void push(input int kind, input int cmd, input int addr, input int data,
                               input string rq);
    ev_t e;
    e.kind = kind; e.cmd = cmd; e.addr = addr; e.data = data; e.rq = rq;
    exp_q.push_back(e);
  endfunction

  function automatic void see(input int kind, input int cmd, input int addr, input int data);
    ev_t e;
    int act, expv;
    act = (kind << 24) | (cmd << 20) | (addr << 8) | (data & 255);
    if (exp_q.size() == 0) begin
      check(0, "unexpected-event", act, 0);
      return;
    end
    e = exp_q.pop_front();
    expv = (e.kind << 24) | (e.cmd << 20) | (e.addr << 8) | (e.data & 255);
    check(e.kind == kind && e.cmd == cmd && e.addr == addr && e.data == data, e.rq, act, expv);
  endfunction

  // memory on the bus
  always @(posedge clk) begin
    #1;
    if (bus_ack) begin
      bus_ack = 0;
    end else if (bus_req) begin
      if (wait_cnt == LAT) begin
        bus_ack   = 1;
        bus_rdata = mem[bus_addr];
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        wait_cnt  = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  always @(posedge clk) snp_d <= snp_valid;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (snp_d) see(2, {snp_hit, snp_supply}, 0, snp_supply ? int'(snp_data) : -1);
      if (bus_req && bus_ack) see(0, bus_cmd, bus_addr, bus_cmd == 2'd3 ? int'(bus_wdata) : -1);
      if (cpu_req && cpu_ready) see(1, 0, cpu_addr, cpu_we ? -1 : int'(cpu_rdata));
    end
  end

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] d, output int lat);
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
      lat++;
    end
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    check(!snp_hit && !snp_supply, "R10 not before capture", snp_hit, 0);
    @(posedge clk); #1;
    snp_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check(!snp_hit, "R10 single-cycle response", snp_hit, 0);
  endtask

  localparam logic [7:0] A = 8'h13, B = 8'h23, C = 8'h05, C2 = 8'h25;

  initial begin
    int lat, lat2;
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!bus_req && !cpu_ready && !snp_hit && !snp_supply, "R1 idle outputs",
          {bus_req, cpu_ready, snp_hit, snp_supply}, 0);
    push(2, 0, 0, -1, "R1 snoop before any fill");
    snoop(2'd0, A);

    // R2 read miss then hit
    push(0, 0, A, -1, "R2 bus read");
    push(1, 0, A, pat(A), "R2 fill data");
    cpu_op(0, A, 0, lat);
    push(1, 0, A, pat(A), "R2 hit data");
    cpu_op(0, A, 0, lat);
    check(lat == 0, "R2 hit same cycle", lat, 0);

    // R4 upgrade, R5 dirty hit
    push(0, 2, A, -1, "R4 invalidate");
    push(1, 0, A, -1, "R4 write done");
    cpu_op(1, A, 8'h11, lat);
    push(1, 0, A, -1, "R5 local write");
    cpu_op(1, A, 8'h22, lat);
    check(lat == 0, "R5 same cycle", lat, 0);

    // R7 snooped read of dirty line
    push(2, 3, 0, 8'h22, "R7 supply dirty");
    snoop(2'd0, A);
    push(0, 2, A, -1, "R7 line now clean");
    push(1, 0, A, -1, "R7 write done");
    cpu_op(1, A, 8'h33, lat);

    // R8 snooped RDX on dirty, INV on clean
    push(2, 3, 0, 8'h33, "R8 rdx supply");
    snoop(2'd1, A);
    push(0, 0, A, -1, "R8 refetch after rdx");
    push(1, 0, A, pat(A), "R8 data");
    cpu_op(0, A, 0, lat);
    push(2, 2, 0, -1, "R8 inv hit no supply");
    snoop(2'd2, A);
    push(0, 0, A, -1, "R8 refetch after inv");
    push(1, 0, A, pat(A), "R8 data2");
    cpu_op(0, A, 0, lat);

    // R7 clean snooped read, R9 ignored snoops
    push(2, 2, 0, -1, "R7 clean hit no supply");
    snoop(2'd0, A);
    push(2, 0, 0, -1, "R9 write-back snoop");
    snoop(2'd3, A);
    push(2, 0, 0, -1, "R9 tag mismatch");
    snoop(2'd1, B);
    push(1, 0, A, pat(A), "R9 line kept");
    cpu_op(0, A, 0, lat);
    check(lat == 0, "R9 still hit", lat, 0);

    // R3 write miss
    push(0, 1, C, -1, "R3 rfo");
    push(1, 0, C, -1, "R3 write done");
    cpu_op(1, C, 8'h44, lat);
    push(1, 0, C, 8'h44, "R3 dirty data");
    cpu_op(0, C, 0, lat);
    check(lat == 0, "R3 hit after install", lat, 0);

    // R6 clean victim, then dirty victims
    push(0, 0, B, -1, "R6 clean victim no wb");
    push(1, 0, B, pat(B), "R6 data");
    cpu_op(0, B, 0, lat);
    push(0, 3, C, 8'h44, "R6 write-back");
    push(0, 1, C2, -1, "R6 rfo after wb");
    push(1, 0, C2, -1, "R6 write done");
    cpu_op(1, C2, 8'h55, lat);
    push(0, 3, C2, 8'h55, "R6 write-back 2");
    push(0, 0, C, -1, "R6 fill");
    push(1, 0, C, 8'h44, "R6 data from memory");
    cpu_op(0, C, 0, lat);

    // R11 hold-off
    push(2, 2, 0, -1, "R11 snoop response");
    push(1, 0, C, 8'h44, "R11 read data");
    fork
      cpu_op(0, C, 0, lat2);
      snoop(2'd0, C);
    join
    check(lat2 == 1, "R11 one cycle hold", lat2, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule